// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day, month and a two-digit year, each as one BCD byte. A one-pulse-per-second tick input advances them, with carries that follow month lengths and leap years. The hours byte carries its own format. With bit 7 set the hour counts 00 to 23. With bit 7 clear the hour counts 12, 01 to 11, and bit 5 marks PM.

A host reaches the bytes through a simple byte-wide request stream, typically fed by a serial target front end. A request with `bus_start` high loads the address pointer. Every accepted request then moves the pointer on by one, so bursts need only one address. A status byte at address 7 holds these bits:
- bit 7: auto-clear-on-read enable
- bit 5: counting halt
- bit 4: time-write enable
- bits 3 to 1: sticky hardware flags, cleared by writing 0
- bit 0: read-only power-fail flag

The request side is valid/ready. A request is taken on a clock edge where `bus_valid` and `bus_ready` are both high. A taken read returns its byte on `rsp_valid`/`rsp_data` one cycle later. That byte stays put until `rsp_ready` is seen high. While a response waits, `bus_ready` is low, so a new request stalls and the pointer does not move. Writes produce no response.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the status byte reads 0x01 and the time bytes at addresses 0 to 5 read 0x00, 0x00, 0x80, 0x01, 0x01, 0x00 (seconds, minutes, hours, day, month, year).
- R2: An accepted request uses `bus_addr` when `bus_start` is high and otherwise the pointer. The pointer becomes that address plus one. Address 6 and addresses 8 and above read 0x00 and ignore writes. Status bits 7, 5 and 4 read back as written, and bit 6 reads 0.
- R3: A read response appears one cycle after acceptance. It stays valid with unchanged data while `rsp_ready` is low. During that time `bus_ready` is low and a waiting request is neither taken nor advances the pointer.
- R4: A write to a time byte changes it only while status bit 4 (time-write enable) is 1. Otherwise the write is ignored.
- R5: Each tick advances seconds in BCD, carrying into minutes at 59. Ticks are ignored while status bit 4 or bit 5 is 1.
- R6: In 24-hour mode (hours bit 7 = 1) the hour runs 00 to 23. After 23:59:59 it returns to 00 with bit 7 kept, and the day advances.
- R7: In 12-hour mode (hours bit 7 = 0, PM = bit 5) the hour goes from 11 to 12 with the PM bit toggled, and from 12 to 01. The day advances only on 11:59:59 PM to 12 AM.
- R8: The day wraps to 01 after the month's last day: 30 in months 04, 06, 09 and 11, 31 in the other months, and 28 in month 02, or 29 when the year is a multiple of 4. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R9: Flags bits 3, 2 and 1 are set by `evt_hit`, `alm_hit` and `bat_hit`. Writing 0 to a flag clears it and writing 1 leaves it unchanged. A hardware set in the same cycle beats the clear.
- R10: With bit 7 set, a read of the status byte returns the current value and then clears bits 3 to 1, except for a flag set by hardware in that same cycle.
- R11: Bit 0 (power-fail) is set by reset and by `pwr_lost`, and status writes do not change it. It clears once all six time bytes have been written during one unbroken period of time-write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| evt_hit | input | 1 | Sets status bit 3 |
| alm_hit | input | 1 | Sets status bit 2 |
| bat_hit | input | 1 | Sets status bit 1 |
| pwr_lost | input | 1 | Sets the power-fail bit |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request can be taken |
| bus_start | input | 1 | Load the pointer from bus_addr |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Start address of a burst |
| bus_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Consumer takes the read byte |
| rsp_data | output | 8 | Read byte |

## Verification
The assertions assume that every byte written to a time register is a legal BCD value for its field. The carry checks hold only for such counts. They also assume that a tick is not counted in the same cycle as an accepted time write; the enable gating guarantees this. The bench writes only calendar-valid dates and hours, and it brackets each burst with a write that sets the enable and one that clears it. Back-pressure is applied only with a read response pending. Hardware flag pulses are driven between clock edges so that their same-cycle priority over a clear is exercised deliberately.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef logic [7:0] bcd_t;

  localparam int N_TIME   = 6;
  localparam int IX_SEC   = 0;
  localparam int IX_MIN   = 1;
  localparam int IX_HOUR  = 2;
  localparam int IX_DAY   = 3;
  localparam int IX_MON   = 4;
  localparam int IX_YEAR  = 5;

  localparam bcd_t TIME_INIT [N_TIME] = '{8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00};

  // increment a valid two-digit BCD byte (caller handles the top wrap)
  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic bcd_leap(input bcd_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic bcd_t bcd_month_len(input bcd_t m, input bcd_t y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bus_port.sv
module rtc_bus_port #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_start,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              rsp_ready,
  input  logic [7:0]        rd_byte,
  output logic              bus_ready,
  output logic              acc,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data
);
  logic [ADDR_W-1:0] ptr_q;

  assign bus_ready = !rsp_valid || rsp_ready;
  assign acc       = bus_valid && bus_ready;
  assign cur_addr  = bus_start ? bus_addr : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      if (acc) ptr_q <= cur_addr + ADDR_W'(1);
      if (acc && !bus_write) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_byte;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R3: a pending response is held, unchanged, until taken
  a_r3_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R3: an accepted read always yields a response next cycle
  a_r3_rsp_follow: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_ready && !bus_write |=> rsp_valid);

  // R3: a stalled request leaves the pointer where it was
  a_r3_stall_ptr: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> $stable(ptr_q));
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [N_TIME-1:0] wr_sel,
  input  bcd_t              wdata,
  output bcd_t              t_q [N_TIME]
);
  bcd_t nxt [N_TIME];
  logic c_min, c_hr, c_day, c_mon, c_yr;
  bcd_t h24_inc, h12_inc, dim;

  always_comb begin
    c_min = (t_q[IX_SEC] == 8'h59);
    nxt[IX_SEC] = c_min ? 8'h00 : bcd_inc(t_q[IX_SEC]);

    c_hr = c_min && (t_q[IX_MIN] == 8'h59);
    nxt[IX_MIN] = c_hr ? 8'h00 : (c_min ? bcd_inc(t_q[IX_MIN]) : t_q[IX_MIN]);

    h24_inc = bcd_inc({2'b00, t_q[IX_HOUR][5:0]});
    h12_inc = bcd_inc({3'b000, t_q[IX_HOUR][4:0]});
    c_day = 1'b0;
    nxt[IX_HOUR] = t_q[IX_HOUR];
    if (c_hr) begin
      if (t_q[IX_HOUR][7]) begin
        if (t_q[IX_HOUR][5:0] >= 6'h23) begin
          nxt[IX_HOUR] = {t_q[IX_HOUR][7:6], 6'h00};
          c_day = 1'b1;
        end else begin
          nxt[IX_HOUR] = {t_q[IX_HOUR][7:6], h24_inc[5:0]};
        end
      end else begin
        if (t_q[IX_HOUR][4:0] == 5'h12) begin
          nxt[IX_HOUR] = {t_q[IX_HOUR][7:5], 5'h01};
        end else if (t_q[IX_HOUR][4:0] == 5'h11) begin
          nxt[IX_HOUR] = {t_q[IX_HOUR][7:6], ~t_q[IX_HOUR][5], 5'h12};
          c_day = t_q[IX_HOUR][5];
        end else begin
          nxt[IX_HOUR] = {t_q[IX_HOUR][7:5], h12_inc[4:0]};
        end
      end
    end

    dim   = bcd_month_len(t_q[IX_MON], t_q[IX_YEAR]);
    c_mon = c_day && (t_q[IX_DAY] >= dim);
    nxt[IX_DAY] = c_mon ? 8'h01 : (c_day ? bcd_inc(t_q[IX_DAY]) : t_q[IX_DAY]);

    c_yr = c_mon && (t_q[IX_MON] >= 8'h12);
    nxt[IX_MON] = c_yr ? 8'h01 : (c_mon ? bcd_inc(t_q[IX_MON]) : t_q[IX_MON]);

    if (c_yr) nxt[IX_YEAR] = (t_q[IX_YEAR] == 8'h99) ? 8'h00 : bcd_inc(t_q[IX_YEAR]);
    else      nxt[IX_YEAR] = t_q[IX_YEAR];
  end

  for (genvar i = 0; i < N_TIME; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)            t_q[i] <= TIME_INIT[i];
      else if (wr_sel[i]) t_q[i] <= wdata;
      else if (advance)   t_q[i] <= nxt[i];
    end
  end

  // R5: minutes move only when seconds pass 59
  a_r5_min_hold: assert property (@(posedge clk) disable iff (rst)
    advance && (wr_sel == '0) && (t_q[IX_SEC] != 8'h59) |=> $stable(t_q[IX_MIN]));

  // R6: the hour format bit survives counting
  a_r6_fmt_kept: assert property (@(posedge clk) disable iff (rst)
    advance && (wr_sel == '0) |=> $stable(t_q[IX_HOUR][7]));
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              st_wr,
  input  logic              st_rd,
  input  logic              wd_arst,
  input  logic              wd_halt,
  input  logic              wd_wen,
  input  logic [2:0]        wd_flags,
  input  logic [2:0]        hits,
  input  logic              pwr_lost,
  input  logic [N_TIME-1:0] time_wr,
  output logic [7:0]        status_byte,
  output logic              wen,
  output logic              halt
);
  logic              arst_q, halt_q, wen_q, pf_q;
  logic [2:0]        flags_q, flags_n;
  logic [N_TIME-1:0] wmask_q;
  logic              full_write;

  assign full_write = (|time_wr) && ((wmask_q | time_wr) == {N_TIME{1'b1}});

  always_comb begin
    flags_n = flags_q;
    if (st_wr) flags_n = flags_n & wd_flags;
    if (st_rd && arst_q) flags_n = 3'b000;
    flags_n = flags_n | hits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arst_q  <= 1'b0;
      halt_q  <= 1'b0;
      wen_q   <= 1'b0;
      flags_q <= 3'b000;
      pf_q    <= 1'b1;
      wmask_q <= '0;
    end else begin
      if (st_wr) begin
        arst_q <= wd_arst;
        halt_q <= wd_halt;
        wen_q  <= wd_wen;
      end
      flags_q <= flags_n;
      wmask_q <= (wen_q && !pwr_lost) ? (wmask_q | time_wr) : '0;
      if (pwr_lost)        pf_q <= 1'b1;
      else if (full_write) pf_q <= 1'b0;
    end
  end

  assign status_byte = {arst_q, 1'b0, halt_q, wen_q, flags_q, pf_q};
  assign wen  = wen_q;
  assign halt = halt_q;

  // R9: writing a one never raises a flag
  a_r9_one_inert: assert property (@(posedge clk) disable iff (rst)
    st_wr && wd_flags[2] && !flags_q[2] && !hits[2] |=> !flags_q[2]);

  // R9: a hardware set is never lost to a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    hits[0] |=> flags_q[0]);

  // R10: auto-clear on a status read
  a_r10_auto_clr: assert property (@(posedge clk) disable iff (rst)
    st_rd && arst_q && !hits[1] |=> !flags_q[1]);

  // R11: power loss always marks the time invalid
  a_r11_pf_set: assert property (@(posedge clk) disable iff (rst)
    pwr_lost |=> pf_q);

  // R11: a status write leaves power-fail alone
  a_r11_pf_wr: assert property (@(posedge clk) disable iff (rst)
    st_wr && !pwr_lost |=> pf_q == $past(pf_q));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int STATUS_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              evt_hit,
  input  logic              alm_hit,
  input  logic              bat_hit,
  input  logic              pwr_lost,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_start,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data
);
  localparam int FLAT_W = 8 * N_TIME;

  logic              acc;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        rd_byte, status_byte;
  logic              wen, halt, advance;
  logic              hit_stat, st_wr, st_rd;
  logic [N_TIME-1:0] hit_time, time_wr;
  bcd_t              t_q [N_TIME];
  logic [FLAT_W-1:0] time_flat;

  rtc_bus_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_start(bus_start),
    .bus_write(bus_write), .bus_addr(bus_addr), .rsp_ready(rsp_ready),
    .rd_byte(rd_byte), .bus_ready(bus_ready), .acc(acc), .cur_addr(cur_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  for (genvar i = 0; i < N_TIME; i++) begin : g_dec
    assign hit_time[i] = (cur_addr == ADDR_W'(i));
    assign time_flat[8*i +: 8] = t_q[i];
  end

  assign hit_stat = (cur_addr == ADDR_W'(STATUS_ADDR));
  assign time_wr  = (acc && bus_write && wen) ? hit_time : '0;
  assign st_wr    = acc && bus_write && hit_stat;
  assign st_rd    = acc && !bus_write && hit_stat;
  assign advance  = tick_1hz && !wen && !halt;

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < N_TIME; i++)
      if (hit_time[i]) rd_byte = t_q[i];
    if (hit_stat) rd_byte = status_byte;
  end

  rtc_status u_status (
    .clk(clk), .rst(rst), .st_wr(st_wr), .st_rd(st_rd),
    .wd_arst(bus_wdata[7]), .wd_halt(bus_wdata[5]), .wd_wen(bus_wdata[4]),
    .wd_flags(bus_wdata[3:1]), .hits({evt_hit, alm_hit, bat_hit}),
    .pwr_lost(pwr_lost), .time_wr(time_wr), .status_byte(status_byte),
    .wen(wen), .halt(halt)
  );

  rtc_time_chain u_chain (
    .clk(clk), .rst(rst), .advance(advance), .wr_sel(time_wr),
    .wdata(bus_wdata), .t_q(t_q)
  );

  // R4: locked time bytes ignore bus writes
  a_r4_locked: assert property (@(posedge clk) disable iff (rst)
    acc && bus_write && (|hit_time) && !wen && !advance |=> $stable(time_flat));

  // R5: gated ticks leave the time untouched
  a_r5_gated: assert property (@(posedge clk) disable iff (rst)
    tick_1hz && (wen || halt) && (time_wr == '0) |=> $stable(time_flat));

  // R3: back-pressure blocks new requests
  a_r3_no_accept: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |-> !bus_ready);
endmodule

// File: tb/sim_rtc_regfile.sv
`timescale 1ns/1ps
module sim_rtc_regfile;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, tick_1hz, evt_hit, alm_hit, bat_hit, pwr_lost;
  logic bus_valid, bus_ready, bus_start, bus_write, rsp_valid, rsp_ready;
  logic [7:0] bus_addr, bus_wdata, rsp_data;
  int n_vec = 0, n_bad = 0;
  logic [7:0] r;
  logic [47:0] tv;

  rtc_regfile u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .evt_hit(evt_hit), .alm_hit(alm_hit),
    .bat_hit(bat_hit), .pwr_lost(pwr_lost), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_start(bus_start), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every task starts and ends at a falling edge
  task automatic beat(input logic wr, input logic st, input logic [7:0] a,
                      input logic [7:0] d, output logic [7:0] q);
    bus_valid = 1'b1; bus_write = wr; bus_start = st; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_start = 1'b0;
    q = rsp_data;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] q;
    beat(1'b1, 1'b1, a, d, q);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] q);
    beat(1'b0, 1'b1, a, 8'h00, q);
  endtask

  task automatic set_time(input logic [47:0] t);
    logic [7:0] q;
    wr_reg(8'd7, 8'h1E);
    for (int i = 0; i < 6; i++) beat(1'b1, i == 0, 8'd0, t[47-8*i -: 8], q);
    wr_reg(8'd7, 8'h0E);
  endtask

  task automatic get_time(output logic [47:0] t);
    logic [7:0] q;
    for (int i = 0; i < 6; i++) begin
      beat(1'b0, i == 0, 8'd0, 8'h00, q);
      t[47-8*i -: 8] = q;
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1hz = 1'b1; @(posedge clk); @(negedge clk); tick_1hz = 1'b0;
    end
  endtask

  task automatic roll(input string tag, input logic [47:0] start, input logic [47:0] exp);
    logic [47:0] t;
    set_time(start);
    tick_n(1);
    get_time(t);
    check(tag, t, exp);
  endtask

  task automatic t_reset;
    logic [47:0] t;
    logic [7:0] q;
    rd_reg(8'd7, q);  check("R1 status", {40'd0, q}, 48'h01);
    get_time(t);      check("R1 time", t, 48'h0000_8001_0100);
  endtask

  task automatic t_power_fail;
    logic [7:0] q;
    logic [47:0] t;
    wr_reg(8'd7, 8'h10);
    rd_reg(8'd7, q);  check("R11 wen keeps pf", {40'd0, q}, 48'h11);
    set_time(48'h0000_8001_0100);
    rd_reg(8'd7, q);  check("R11 pf cleared", {40'd0, q}, 48'h00);
    wr_reg(8'd7, 8'h01);
    rd_reg(8'd7, q);  check("R11 write no pf", {40'd0, q}, 48'h00);
    pwr_lost = 1'b1; @(posedge clk); @(negedge clk); pwr_lost = 1'b0;
    rd_reg(8'd7, q);  check("R11 pwr_lost", {40'd0, q}, 48'h01);
    wr_reg(8'd7, 8'h10);
    for (int i = 0; i < 3; i++) beat(1'b1, i == 0, 8'd0, 8'h00, q);
    wr_reg(8'd7, 8'h00);
    wr_reg(8'd7, 8'h10);
    for (int i = 0; i < 3; i++) beat(1'b1, i == 0, 8'd3, 8'h01, q);
    rd_reg(8'd7, q);  check("R11 broken burst", {40'd0, q}, 48'h11);
    set_time(48'h1234_9515_0624);
    rd_reg(8'd7, q);  check("R11 full burst", {40'd0, q}, 48'h00);
    get_time(t);      check("R4 burst stored", t, 48'h1234_9515_0624);
  endtask

  task automatic t_lock_and_map;
    logic [7:0] q;
    logic [47:0] t;
    wr_reg(8'd0, 8'h42);
    get_time(t);      check("R4 locked write", t, 48'h1234_9515_0624);
    wr_reg(8'd7, 8'h10);
    wr_reg(8'd6, 8'h55);
    wr_reg(8'd7, 8'h00);
    beat(1'b0, 1'b1, 8'd5, 8'h00, q); check("R2 start addr", {40'd0, q}, 48'h24);
    beat(1'b0, 1'b0, 8'd0, 8'h00, q); check("R2 addr6 zero", {40'd0, q}, 48'h00);
    beat(1'b0, 1'b0, 8'd0, 8'h00, q); check("R2 incr status", {40'd0, q}, 48'h00);
    beat(1'b0, 1'b0, 8'd0, 8'h00, q); check("R2 addr8 zero", {40'd0, q}, 48'h00);
    wr_reg(8'd7, 8'hE0);
    rd_reg(8'd7, q);  check("R2 ctl bits", {40'd0, q}, 48'hA0);
    wr_reg(8'd7, 8'h00);
  endtask

  task automatic t_ticks;
    logic [47:0] t;
    roll("R5 digit carry", 48'h0900_8101_0124, 48'h1000_8101_0124);
    roll("R5 min carry", 48'h5959_8501_0124, 48'h0000_8601_0124);
    set_time(48'h3012_8101_0124);
    wr_reg(8'd7, 8'h10); tick_n(2); wr_reg(8'd7, 8'h20); tick_n(2); wr_reg(8'd7, 8'h00);
    get_time(t);      check("R5 gated ticks", t, 48'h3012_8101_0124);
    tick_n(3);
    get_time(t);      check("R5 three ticks", t, 48'h3312_8101_0124);
  endtask

  task automatic t_calendar;
    roll("R6 midnight", 48'h5959_A328_0223, 48'h0000_8001_0323);
    roll("R8 leap feb", 48'h5959_A328_0224, 48'h0000_8029_0224);
    roll("R8 feb29 end", 48'h5959_A329_0224, 48'h0000_8001_0324);
    roll("R8 april end", 48'h5959_A330_0450, 48'h0000_8001_0550);
    roll("R8 year wrap", 48'h5959_A331_1299, 48'h0000_8001_0100);
    roll("R6 mid day", 48'h5959_8915_0750, 48'h0000_9015_0750);
  endtask

  task automatic t_twelve;
    roll("R7 noon", 48'h5959_1115_0324, 48'h0000_3215_0324);
    roll("R7 midnight", 48'h5959_3115_0324, 48'h0000_1216_0324);
    roll("R7 twelve am", 48'h5959_1215_0324, 48'h0000_0115_0324);
    roll("R7 one pm", 48'h5959_3215_0324, 48'h0000_2115_0324);
  endtask

  task automatic t_flags;
    logic [7:0] q;
    wr_reg(8'd7, 8'h00);
    evt_hit = 1'b1; @(posedge clk); @(negedge clk); evt_hit = 1'b0;
    alm_hit = 1'b1; @(posedge clk); @(negedge clk); alm_hit = 1'b0;
    rd_reg(8'd7, q);  check("R9 hw set", {40'd0, q}, 48'h0C);
    wr_reg(8'd7, 8'h0E);
    rd_reg(8'd7, q);  check("R9 write one inert", {40'd0, q}, 48'h0C);
    wr_reg(8'd7, 8'h06);
    rd_reg(8'd7, q);  check("R9 write zero", {40'd0, q}, 48'h04);
    bat_hit = 1'b1; wr_reg(8'd7, 8'h00); bat_hit = 1'b0;
    rd_reg(8'd7, q);  check("R9 set beats clear", {40'd0, q}, 48'h02);
    wr_reg(8'd7, 8'h00);
  endtask

  task automatic t_auto_clear;
    logic [7:0] q;
    wr_reg(8'd7, 8'h80);
    evt_hit = 1'b1; @(posedge clk); @(negedge clk); evt_hit = 1'b0;
    rd_reg(8'd7, q);  check("R10 read value", {40'd0, q}, 48'h88);
    rd_reg(8'd7, q);  check("R10 cleared", {40'd0, q}, 48'h80);
    evt_hit = 1'b1; bat_hit = 1'b1; @(posedge clk); @(negedge clk);
    evt_hit = 1'b0; bat_hit = 1'b0;
    alm_hit = 1'b1; rd_reg(8'd7, q); alm_hit = 1'b0;
    check("R10 read with set", {40'd0, q}, 48'h8A);
    rd_reg(8'd7, q);  check("R10 set survives", {40'd0, q}, 48'h84);
    wr_reg(8'd7, 8'h00);
    evt_hit = 1'b1; @(posedge clk); @(negedge clk); evt_hit = 1'b0;
    rd_reg(8'd7, q);
    rd_reg(8'd7, q);  check("R10 off keeps flag", {40'd0, q}, 48'h08);
  endtask

  task automatic t_backpressure;
    logic [7:0] q;
    rsp_ready = 1'b0;
    bus_valid = 1'b1; bus_write = 1'b0; bus_start = 1'b1; bus_addr = 8'd7;
    @(posedge clk); @(negedge clk);
    bus_addr = 8'd0;
    check("R3 rsp valid", {47'd0, rsp_valid}, 48'd1);
    check("R3 ready low", {47'd0, bus_ready}, 48'd0);
    check("R3 rsp data", {40'd0, rsp_data}, 48'h08);
    @(posedge clk); @(negedge clk);
    check("R3 held data", {39'd0, rsp_valid, rsp_data}, {39'd0, 1'b1, 8'h08});
    bus_valid = 1'b0; bus_start = 1'b0; rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 drained", {47'd0, rsp_valid}, 48'd0);
    beat(1'b0, 1'b0, 8'd0, 8'h00, q);
    check("R3 stall kept pointer", {40'd0, q}, 48'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; tick_1hz = 1'b0; evt_hit = 1'b0; alm_hit = 1'b0; bat_hit = 1'b0;
    pwr_lost = 1'b0; bus_valid = 1'b0; bus_start = 1'b0; bus_write = 1'b0;
    bus_addr = 8'h00; bus_wdata = 8'h00; rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_power_fail();
    t_lock_and_map();
    t_ticks();
    t_calendar();
    t_twelve();
    t_flags();
    t_auto_clear();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule